// File: doc/BRIEF.md
# Ethernet Receive Frame Validator

This block sits behind a receive front end that delivers one byte per clock while `i_valid` is high. It locks onto the start of a frame by checking the preamble and start-of-frame delimiter (SFD). It then counts the frame bytes and captures the destination address and the type/length field. It also watches the receive-error line. If the frame runs past the length limit, or the PHY signals a receive error, it raises a one-cycle abort so the memory path stops writing at once. The first idle cycle after the frame carries the FCS-check result from an external CRC unit and a dribble-nibble flag. In the cycle after that idle cycle the block gives one good/bad verdict and a vector of statistic increment pulses.

A frame is one unbroken run of `i_valid` cycles. It ends at the first cycle with `i_valid` low, and at least one idle cycle separates frames. Frame length counts every byte after the SFD, from the first destination-address byte through the last FCS byte. A jumbo mode raises the length limit for frames that start while it is selected.

Top module: `eth_rx_frame_check`

## Requirements
- R1: A run becomes a frame only if it starts with at least MIN_PRE (default 2) bytes of 0x55 followed by 0xD5. A run that starts with any other byte, has too few 0x55 bytes, or has any other byte before the 0xD5 is dropped: it produces no verdict, no statistic, no address and no abort.
- R2: Every accepted frame produces exactly one `o_done` pulse. The pulse comes one cycle after the first `i_valid`-low cycle. `o_good` is high with it only when FCS is ok, no receive error was seen, and the length is between 64 and the active limit.
- R3: A frame shorter than 64 bytes is judged bad and raises the short-frame bit.
- R4: With jumbo mode off, the limit is 1518 bytes. The byte that brings the count to the limit plus one raises `o_abort` for one cycle, in the cycle after that byte. A frame raises at most one abort.
- R5: The jumbo select is sampled on the SFD byte and holds for the whole frame. While it is set, the limit is 10240 bytes. A change of the select after the SFD has no effect on that frame.
- R6: `i_rx_er` high on any frame byte raises `o_abort` in the next cycle (unless the frame has already aborted). It also makes the frame bad and raises the symbol-error bit.
- R7: A frame over the limit raises the long-frame bit if FCS is ok, and the jabber bit if FCS is bad. It never raises both.
- R8: A frame within the limit that fails FCS raises the alignment bit if it ended with a dribble nibble. Otherwise, if it is also not short, it raises the FCS-error bit. A dribble nibble with good FCS raises nothing.
- R9: For a frame between 64 bytes and the limit whose type/length value is below 0x0600, the length-mismatch bit is raised when the value does not match the payload count (length minus 18). A value below 46 must match a padded payload of 46. This bit does not change the verdict.
- R10: The six destination-address bytes, first byte in bits 47:40, appear on `o_da` with a one-cycle `o_da_valid` in the cycle after the sixth frame byte.
- R11: `o_stat` pulses only together with `o_done`. Its bit positions are: 0 alignment, 1 FCS, 2 short, 3 long, 4 jabber, 5 symbol, 6 length mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_jumbo_en | input | 1 | Jumbo length limit select, sampled at SFD |
| i_valid | input | 1 | Byte valid from receive front end |
| i_byte | input | 8 | Received byte |
| i_dribble | input | 1 | Frame ended on a nibble boundary (sampled in the first idle cycle) |
| i_rx_er | input | 1 | PHY receive error |
| i_fcs_ok | input | 1 | External CRC result (sampled in the first idle cycle) |
| o_abort | output | 1 | Early bad-frame pulse to the memory path |
| o_done | output | 1 | End-of-frame verdict strobe |
| o_good | output | 1 | Verdict: frame is good |
| o_stat | output | 7 | Statistic increment pulses |
| o_da | output | 48 | Captured destination address |
| o_da_valid | output | 1 | Destination address strobe |

## Verification
The early abort and the address strobe can both fire in the same cycle. This happens when the receive-error line is raised on the sixth destination-address byte, because both outputs are registered from that one byte. The bench drives exactly that case. It requires both pulses in the same cycle, the full address value, and a verdict that is bad with only the symbol bit set. The abort on overlength is judged in the same way, by the byte index at which it lands.

// File: rtl/eth_rxv_pkg.sv
package eth_rxv_pkg;
  localparam logic [7:0]  PRE_BYTE   = 8'h55;
  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam int          MAC_BYTES  = 6;
  localparam int          TYPE_OFS   = 2 * MAC_BYTES;
  localparam int          HDR_BYTES  = TYPE_OFS + 2;
  localparam int          FCS_BYTES  = 4;
  localparam int          MIN_PAY    = 46;
  localparam logic [15:0] TYPE_FLOOR = 16'h0600;
  localparam int          NSTAT      = 7;

  localparam int ST_ALIGN = 0;
  localparam int ST_FCS   = 1;
  localparam int ST_SHORT = 2;
  localparam int ST_LONG  = 3;
  localparam int ST_JAB   = 4;
  localparam int ST_SYM   = 5;
  localparam int ST_LMIS  = 6;

  typedef enum logic [1:0] {SY_IDLE, SY_PRE, SY_DATA, SY_DROP} sync_st_e;
endpackage

// File: rtl/eth_rxv_sync.sv
module eth_rxv_sync
  import eth_rxv_pkg::*;
#(
  parameter int MIN_PRE = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       i_valid,
  input  logic [7:0] i_byte,
  output logic       o_sfd,
  output logic       o_strobe,
  output logic       o_end
);
  localparam int PCW = $clog2(MIN_PRE + 2);
  localparam logic [PCW-1:0] NEED = PCW'(MIN_PRE);
  localparam logic [PCW-1:0] PMAX = {PCW{1'b1}};

  sync_st_e       st_q;
  logic [PCW-1:0] pcnt_q;

  always_comb begin
    o_sfd    = (st_q == SY_PRE) && i_valid && (i_byte == SFD_BYTE) && (pcnt_q >= NEED);
    o_strobe = (st_q == SY_DATA) && i_valid;
    o_end    = (st_q == SY_DATA) && !i_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SY_IDLE;
      pcnt_q <= '0;
    end else begin
      unique case (st_q)
        SY_IDLE: begin
          pcnt_q <= '0;
          if (i_valid) begin
            if (i_byte == PRE_BYTE) begin
              st_q   <= SY_PRE;
              pcnt_q <= PCW'(1);
            end else begin
              st_q <= SY_DROP;
            end
          end
        end
        SY_PRE: begin
          if (!i_valid) begin
            st_q <= SY_IDLE;
          end else if (i_byte == PRE_BYTE) begin
            if (pcnt_q != PMAX) pcnt_q <= pcnt_q + PCW'(1);
          end else if (o_sfd) begin
            st_q <= SY_DATA;
          end else begin
            st_q <= SY_DROP;
          end
        end
        SY_DATA: if (!i_valid) st_q <= SY_IDLE;
        SY_DROP: if (!i_valid) st_q <= SY_IDLE;
        default: st_q <= SY_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eth_rxv_track.sv
module eth_rxv_track
  import eth_rxv_pkg::*;
#(
  parameter int STD_MAX   = 1518,
  parameter int JUMBO_MAX = 10240,
  parameter int LW        = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   i_sfd,
  input  logic                   i_strobe,
  input  logic [7:0]             i_byte,
  input  logic                   i_rx_er,
  input  logic                   i_jumbo_en,
  output logic [LW-1:0]          o_len,
  output logic                   o_over,
  output logic                   o_rxer_seen,
  output logic [15:0]            o_type,
  output logic [8*MAC_BYTES-1:0] o_da,
  output logic                   o_da_valid,
  output logic                   o_abort
);
  localparam int DAW = 8 * MAC_BYTES;
  typedef logic [LW-1:0] len_t;
  localparam len_t CAP_L   = len_t'(JUMBO_MAX + 1);
  localparam len_t STD_L   = len_t'(STD_MAX);
  localparam len_t JUMBO_L = len_t'(JUMBO_MAX);
  localparam len_t DA_N    = len_t'(MAC_BYTES);
  localparam len_t DA_LAST = len_t'(MAC_BYTES - 1);
  localparam len_t TY_HI   = len_t'(TYPE_OFS);
  localparam len_t TY_LO   = len_t'(TYPE_OFS + 1);

  len_t           len_q, len_inc, limit;
  logic           jumbo_q, rxer_q, aborted_q, abort_q, da_v_q;
  logic [15:0]    type_q;
  logic [DAW-1:0] da_q;

  always_comb begin
    limit   = jumbo_q ? JUMBO_L : STD_L;
    len_inc = (len_q == CAP_L) ? len_q : len_q + len_t'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q     <= '0;
      jumbo_q   <= 1'b0;
      rxer_q    <= 1'b0;
      aborted_q <= 1'b0;
      abort_q   <= 1'b0;
      da_v_q    <= 1'b0;
      type_q    <= '0;
      da_q      <= '0;
    end else begin
      abort_q <= 1'b0;
      da_v_q  <= 1'b0;
      if (i_sfd) begin
        len_q     <= '0;
        jumbo_q   <= i_jumbo_en;
        rxer_q    <= 1'b0;
        aborted_q <= 1'b0;
      end else if (i_strobe) begin
        len_q <= len_inc;
        if (i_rx_er) rxer_q <= 1'b1;
        if (!aborted_q && ((len_inc > limit) || i_rx_er)) begin
          abort_q   <= 1'b1;
          aborted_q <= 1'b1;
        end
        if (len_q < DA_N)    da_q <= {da_q[DAW-9:0], i_byte};
        if (len_q == DA_LAST) da_v_q <= 1'b1;
        if (len_q == TY_HI)  type_q[15:8] <= i_byte;
        if (len_q == TY_LO)  type_q[7:0]  <= i_byte;
      end
    end
  end

  assign o_len       = len_q;
  assign o_over      = len_q > limit;
  assign o_rxer_seen = rxer_q;
  assign o_type      = type_q;
  assign o_da        = da_q;
  assign o_da_valid  = da_v_q;
  assign o_abort     = abort_q;
endmodule

// File: rtl/eth_rxv_judge.sv
module eth_rxv_judge
  import eth_rxv_pkg::*;
#(
  parameter int MIN_FRAME = 64,
  parameter int LW        = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_end,
  input  logic [LW-1:0]    i_len,
  input  logic             i_over,
  input  logic             i_rxer_seen,
  input  logic [15:0]      i_type,
  input  logic             i_fcs_ok,
  input  logic             i_dribble,
  output logic             o_done,
  output logic             o_good,
  output logic [NSTAT-1:0] o_stat
);
  localparam logic [LW-1:0] MIN_L = LW'(MIN_FRAME);

  logic             short_f, bad_fcs, mism;
  logic [31:0]      pay, typ;
  logic [NSTAT-1:0] stat_n;
  logic             done_q, good_q;
  logic [NSTAT-1:0] stat_q;

  always_comb begin
    short_f = i_len < MIN_L;
    bad_fcs = !i_fcs_ok;
    pay     = 32'(i_len) - 32'(HDR_BYTES + FCS_BYTES);
    typ     = 32'(i_type);
    mism    = (i_type < TYPE_FLOOR) &&
              ((typ >= 32'(MIN_PAY)) ? (pay != typ) : (pay != 32'(MIN_PAY)));
    stat_n           = '0;
    stat_n[ST_ALIGN] = i_dribble && bad_fcs && !i_over;
    stat_n[ST_FCS]   = !i_dribble && bad_fcs && !i_over && !short_f;
    stat_n[ST_SHORT] = short_f;
    stat_n[ST_LONG]  = i_over && i_fcs_ok;
    stat_n[ST_JAB]   = i_over && bad_fcs;
    stat_n[ST_SYM]   = i_rxer_seen;
    stat_n[ST_LMIS]  = mism && !short_f && !i_over;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      good_q <= 1'b0;
      stat_q <= '0;
    end else begin
      done_q <= i_end;
      good_q <= i_end && i_fcs_ok && !i_rxer_seen && !short_f && !i_over;
      stat_q <= i_end ? stat_n : '0;
    end
  end

  assign o_done = done_q;
  assign o_good = good_q;
  assign o_stat = stat_q;
endmodule

// File: rtl/eth_rx_frame_check.sv
module eth_rx_frame_check
  import eth_rxv_pkg::*;
#(
  parameter int MIN_PRE   = 2,
  parameter int MIN_FRAME = 64,
  parameter int STD_MAX   = 1518,
  parameter int JUMBO_MAX = 10240
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        i_jumbo_en,
  input  logic        i_valid,
  input  logic [7:0]  i_byte,
  input  logic        i_dribble,
  input  logic        i_rx_er,
  input  logic        i_fcs_ok,
  output logic        o_abort,
  output logic        o_done,
  output logic        o_good,
  output logic [6:0]  o_stat,
  output logic [47:0] o_da,
  output logic        o_da_valid
);
  localparam int LW = $clog2(JUMBO_MAX + 2);

  logic          sfd, strobe, fend, over, rxer_seen;
  logic [LW-1:0] len;
  logic [15:0]   typ;

  eth_rxv_sync #(.MIN_PRE(MIN_PRE)) u_sync (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_byte(i_byte),
    .o_sfd(sfd), .o_strobe(strobe), .o_end(fend)
  );

  eth_rxv_track #(.STD_MAX(STD_MAX), .JUMBO_MAX(JUMBO_MAX), .LW(LW)) u_track (
    .clk(clk), .rst(rst), .i_sfd(sfd), .i_strobe(strobe), .i_byte(i_byte),
    .i_rx_er(i_rx_er), .i_jumbo_en(i_jumbo_en), .o_len(len), .o_over(over),
    .o_rxer_seen(rxer_seen), .o_type(typ), .o_da(o_da),
    .o_da_valid(o_da_valid), .o_abort(o_abort)
  );

  eth_rxv_judge #(.MIN_FRAME(MIN_FRAME), .LW(LW)) u_judge (
    .clk(clk), .rst(rst), .i_end(fend), .i_len(len), .i_over(over),
    .i_rxer_seen(rxer_seen), .i_type(typ), .i_fcs_ok(i_fcs_ok),
    .i_dribble(i_dribble), .o_done(o_done), .o_good(o_good), .o_stat(o_stat)
  );
endmodule

// File: rtl/eth_rx_frame_check_sva.sv
module eth_rx_frame_check_sva (
  input logic       clk,
  input logic       rst,
  input logic       i_valid,
  input logic       o_abort,
  input logic       o_done,
  input logic       o_good,
  input logic [6:0] o_stat,
  input logic       o_da_valid
);
  assert_abort_single_R4: assert property (@(posedge clk) disable iff (rst)
    o_abort |=> !o_abort);
  assert_abort_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    o_abort |-> $past(i_valid));
  assert_done_after_gap_R2: assert property (@(posedge clk) disable iff (rst)
    o_done |-> !$past(i_valid));
  assert_good_clean_R2: assert property (@(posedge clk) disable iff (rst)
    o_good |-> (o_done && (o_stat[5:0] == 6'd0)));
  assert_long_xor_jabber_R7: assert property (@(posedge clk) disable iff (rst)
    o_done |-> !(o_stat[3] && o_stat[4]));
  assert_short_not_long_R3: assert property (@(posedge clk) disable iff (rst)
    o_done |-> !(o_stat[2] && (o_stat[3] || o_stat[4])));
  assert_stat_with_done_R11: assert property (@(posedge clk) disable iff (rst)
    (o_stat != 7'd0) |-> o_done);
  assert_da_apart_R10: assert property (@(posedge clk) disable iff (rst)
    o_da_valid |-> !o_done);
endmodule

bind eth_rx_frame_check eth_rx_frame_check_sva u_sva (
  .clk(clk), .rst(rst), .i_valid(i_valid), .o_abort(o_abort), .o_done(o_done),
  .o_good(o_good), .o_stat(o_stat), .o_da_valid(o_da_valid)
);

// File: tb/eth_rx_frame_check_bench.sv
module eth_rx_frame_check_bench;
  localparam logic [6:0] S_ALIGN = 7'b0000001;
  localparam logic [6:0] S_FCS   = 7'b0000010;
  localparam logic [6:0] S_SHORT = 7'b0000100;
  localparam logic [6:0] S_LONG  = 7'b0001000;
  localparam logic [6:0] S_JAB   = 7'b0010000;
  localparam logic [6:0] S_SYM   = 7'b0100000;
  localparam logic [6:0] S_LMIS  = 7'b1000000;
  localparam logic [47:0] DA     = 48'h021AB34C5D6E;

  logic clk = 1'b0, rst = 1'b1, jumbo = 1'b0, valid = 1'b0;
  logic dribble = 1'b0, rxer = 1'b0, fcs = 1'b0;
  logic [7:0] byt = 8'h00;
  logic o_abort, o_done, o_good, o_da_valid;
  logic [6:0] o_stat;
  logic [47:0] o_da;

  eth_rx_frame_check u_eth_rx_frame_check (
    .clk(clk), .rst(rst), .i_jumbo_en(jumbo), .i_valid(valid), .i_byte(byt),
    .i_dribble(dribble), .i_rx_er(rxer), .i_fcs_ok(fcs), .o_abort(o_abort),
    .o_done(o_done), .o_good(o_good), .o_stat(o_stat), .o_da(o_da),
    .o_da_valid(o_da_valid)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cur_idx = -1;
  int n_done = 0, n_abort = 0, n_da = 0, abort_idx = -1;
  logic m_good = 1'b0, both = 1'b0;
  logic [6:0] m_stat = '0;
  logic [47:0] m_da = '0;

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (o_done) begin n_done++; m_good = o_good; m_stat = o_stat; end
      if (o_abort) begin n_abort++; abort_idx = cur_idx; end
      if (o_da_valid) begin n_da++; m_da = o_da; if (o_abort) both = 1'b1; end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int npre, input logic [7:0] sfdb, input int len,
                      input logic [15:0] typ, input logic fcs_ok, input logic drib,
                      input int rxer_idx, input logic jmb, input logic jmb_after);
    n_done = 0; n_abort = 0; n_da = 0; abort_idx = -1; both = 1'b0;
    m_good = 1'b0; m_stat = '0; m_da = '0;
    jumbo = jmb;
    for (int i = 0; i < npre; i++) begin
      @(negedge clk); valid = 1'b1; byt = 8'h55; cur_idx = -1;
    end
    @(negedge clk); valid = 1'b1; byt = sfdb; cur_idx = -1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      jumbo = jmb_after;
      cur_idx = i;
      rxer = (i == rxer_idx);
      if (i < 6) byt = DA[47 - 8*i -: 8];
      else if (i == 12) byt = typ[15:8];
      else if (i == 13) byt = typ[7:0];
      else byt = 8'(i) ^ 8'hA5;
    end
    @(negedge clk); valid = 1'b0; rxer = 1'b0; fcs = fcs_ok; dribble = drib; cur_idx = -1;
    @(negedge clk); fcs = 1'b0; dribble = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_frame(input string req, input logic g, input logic [6:0] st,
                              input int nab, input int abidx);
    chk(req, "verdict count", 64'(n_done), 64'd1);
    chk(req, "good", 64'(m_good), 64'(g));
    chk(req, "stat", 64'(m_stat), 64'(st));
    chk(req, "abort count", 64'(n_abort), 64'(nab));
    if (nab > 0) chk(req, "abort byte index", 64'(abort_idx), 64'(abidx));
    chk(req, "da strobes", 64'(n_da), 64'd1);
    chk(req, "da value", 64'(m_da), 64'(DA));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R2", "reset done", 64'(o_done), 64'd0);
    chk("R4", "reset abort", 64'(o_abort), 64'd0);
    chk("R11", "reset stat", 64'(o_stat), 64'd0);
    chk("R10", "reset da", {15'd0, o_da_valid, o_da}, 64'd0);
  endtask

  task automatic t_basic();
    send(7, 8'hD5, 64, 16'h0800, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    expect_frame("R2", 1'b1, 7'd0, 0, 0);
    send(2, 8'hD5, 63, 16'h0800, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    expect_frame("R3", 1'b0, S_SHORT, 0, 0);
  endtask

  task automatic t_limit();
    send(7, 8'hD5, 1518, 16'h0800, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    expect_frame("R4", 1'b1, 7'd0, 0, 0);
    send(7, 8'hD5, 1519, 16'h0800, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    expect_frame("R7_long", 1'b0, S_LONG, 1, 1518);
    send(7, 8'hD5, 1600, 16'h0800, 1'b0, 1'b1, -1, 1'b0, 1'b0);
    expect_frame("R7_jabber", 1'b0, S_JAB, 1, 1518);
  endtask

  task automatic t_jumbo();
    send(7, 8'hD5, 10240, 16'h0800, 1'b1, 1'b0, -1, 1'b1, 1'b1);
    expect_frame("R5", 1'b1, 7'd0, 0, 0);
    send(7, 8'hD5, 10241, 16'h0800, 1'b1, 1'b0, -1, 1'b1, 1'b1);
    expect_frame("R5", 1'b0, S_LONG, 1, 10240);
    send(7, 8'hD5, 1519, 16'h0800, 1'b1, 1'b0, -1, 1'b0, 1'b1);
    expect_frame("R5_late_select", 1'b0, S_LONG, 1, 1518);
    jumbo = 1'b0;
  endtask

  task automatic t_rxer();
    send(7, 8'hD5, 80, 16'h0800, 1'b1, 1'b0, 20, 1'b0, 1'b0);
    expect_frame("R6", 1'b0, S_SYM, 1, 20);
  endtask

  task automatic t_align();
    send(7, 8'hD5, 100, 16'h0800, 1'b0, 1'b1, -1, 1'b0, 1'b0);
    expect_frame("R8_align", 1'b0, S_ALIGN, 0, 0);
    send(7, 8'hD5, 100, 16'h0800, 1'b0, 1'b0, -1, 1'b0, 1'b0);
    expect_frame("R8_fcs", 1'b0, S_FCS, 0, 0);
    send(7, 8'hD5, 100, 16'h0800, 1'b1, 1'b1, -1, 1'b0, 1'b0);
    expect_frame("R8_dribble_ok", 1'b1, 7'd0, 0, 0);
  endtask

  task automatic t_lenfield();
    send(7, 8'hD5, 64, 16'h0010, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    expect_frame("R9_padded", 1'b1, 7'd0, 0, 0);
    send(7, 8'hD5, 64, 16'h0030, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    expect_frame("R9_mismatch", 1'b1, S_LMIS, 0, 0);
    send(7, 8'hD5, 118, 16'd100, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    expect_frame("R9_exact", 1'b1, 7'd0, 0, 0);
    send(7, 8'hD5, 119, 16'd100, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    expect_frame("R9_off_by_one", 1'b1, S_LMIS, 0, 0);
  endtask

  task automatic t_preamble();
    send(7, 8'h12, 70, 16'h0800, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    chk("R1", "bad sfd verdicts", 64'(n_done + n_abort + n_da), 64'd0);
    send(1, 8'hD5, 70, 16'h0800, 1'b1, 1'b0, 3, 1'b0, 1'b0);
    chk("R1", "short preamble outputs", 64'(n_done + n_abort + n_da), 64'd0);
    send(0, 8'hD5, 70, 16'h0800, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    chk("R1", "no preamble outputs", 64'(n_done + n_abort + n_da), 64'd0);
    send(2, 8'hD5, 70, 16'h0800, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    expect_frame("R1_min_preamble", 1'b1, 7'd0, 0, 0);
  endtask

  task automatic t_overlap();
    send(7, 8'hD5, 64, 16'h0800, 1'b1, 1'b0, 5, 1'b0, 1'b0);
    expect_frame("R10_R6_same_cycle", 1'b0, S_SYM, 1, 5);
    chk("R10", "abort with da strobe", 64'(both), 64'd1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_limit();
    t_jumbo();
    t_rxer();
    t_align();
    t_lenfield();
    t_preamble();
    t_overlap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule